// File: doc/BRIEF.md
# Lane-Masked Multicast Configuration Register Bank

This block is a small register file on a plain address/data bus. It holds configuration for four serializer lanes. A global control word carries a 4-bit lane-select mask, PLL settings and spare fields. Two further addresses are per-lane registers: each lane keeps its own copy of both.

A single bus write to either per-lane address is copied into every lane whose mask bit is set. Lanes whose mask bit is clear keep their old value. This lets software program several lanes with one access.

Reads of a per-lane address return the copy of the one lane named by the mask. If the mask does not select exactly one lane, the read returns zero and raises an invalid flag. The per-lane copies drive the lane configuration outputs directly. The global word drives the PLL multiplier, the loop-bandwidth code and a PLL enable that is gated by power-down controls.

Top module: `lane_cfg_bank`

## Requirements
- R1: After reset the global word at address 0x06 reads 0xF115. Every per-lane copy of 0x07 and 0x08 is zero.
- R2: A write to 0x06 stores all 16 bits, including the spare bits 11:10 and 6:5. A later read of 0x06 returns the written value.
- R3: A write to 0x07 stores wdata into the first-register copy of each lane n whose mask bit (global bit 12+n) is 1.
- R4: A write to 0x08 stores wdata into the second-register copy of each lane n whose mask bit is 1. During any per-lane write, lanes whose mask bit is 0 keep their previous value.
- R5: When the mask is one-hot, a read of 0x07 or 0x08 returns the copy of the selected lane, and rd_invalid is 0. Mask 0001 selects lane 0, 0010 lane 1, 0100 lane 2 and 1000 lane 3.
- R6: When the mask is not one-hot (zero, or two or more bits set), a read of 0x07 or 0x08 returns 0 with rd_invalid at 1.
- R7: pll_en equals global bit 4, forced to 0 while pd_n is 0 or glob_pd is 1.
- R8: mpy mirrors global bits 3:0 (reset 0101). loop_bw mirrors global bits 9:8 (reset 01).
- R9: Any address other than 0x06, 0x07 and 0x08 reads as 0 with rd_invalid at 0. A write to such an address changes no state.
- R10: A write takes effect on the clock edge at which we is sampled high. Before that edge, reads and outputs still show the old value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| we | input | 1 | Write strobe |
| addr | input | 8 | Register address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Combinational read data for addr |
| rd_invalid | output | 1 | Per-lane read with a non-one-hot mask |
| pd_n | input | 1 | Active-low power-down |
| glob_pd | input | 1 | Global power-down control, active high |
| pll_en | output | 1 | Effective PLL enable |
| loop_bw | output | 2 | PLL loop-bandwidth code |
| mpy | output | 4 | PLL multiplier code |
| lane_a | output | 64 | First per-lane register, lane n at bits 16n+15:16n |
| lane_b | output | 64 | Second per-lane register, lane n at bits 16n+15:16n |

## Verification
A wrong copy in any lane shows on lane_a or lane_b one cycle after the write that caused it. The bench compares all lane outputs with its model after every access, so a bad copy is caught even if no read ever selects that lane. A fault in the mask decode shows either as a lane that changes when it should hold, or as a read that returns data where it should be flagged invalid. A wrong global field shows at once on pll_en, mpy or loop_bw.

// File: rtl/lane_cfg_bank.sv
module lane_cfg_bank #(
  parameter int NLANE = 4,
  parameter int DW = 16,
  parameter int AW = 8,
  parameter logic [AW-1:0] ADDR_GLB = 8'h06,
  parameter logic [AW-1:0] ADDR_A = 8'h07,
  parameter logic [AW-1:0] ADDR_B = 8'h08,
  parameter logic [DW-1:0] GLB_RST = 16'hF115,
  parameter int MASK_LSB = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [AW-1:0]     addr,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     rdata,
  output logic              rd_invalid,
  input  logic              pd_n,
  input  logic              glob_pd,
  output logic              pll_en,
  output logic [1:0]        loop_bw,
  output logic [3:0]        mpy,
  output logic [NLANE*DW-1:0] lane_a,
  output logic [NLANE*DW-1:0] lane_b
);
  logic [DW-1:0]    glb;
  logic [NLANE-1:0] mask;
  logic             onehot;
  logic [DW-1:0]    sel_a, sel_b;

  assign mask   = glb[MASK_LSB +: NLANE];
  assign onehot = (mask != '0) && ((mask & (mask - 1'b1)) == '0);
  assign pll_en = glb[4] & pd_n & ~glob_pd;
  assign loop_bw = glb[9:8];
  assign mpy    = glb[3:0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) glb <= GLB_RST;
    else if (we && addr == ADDR_GLB) glb <= wdata;

  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        lane_a[g*DW +: DW] <= '0;
        lane_b[g*DW +: DW] <= '0;
      end else if (we && mask[g]) begin
        if (addr == ADDR_A) lane_a[g*DW +: DW] <= wdata;
        if (addr == ADDR_B) lane_b[g*DW +: DW] <= wdata;
      end

    // R3
    lane_a_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (we && addr == ADDR_A && mask[g]) |=> lane_a[g*DW +: DW] == $past(wdata));
    // R4
    lane_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!mask[g] || !we) |=> $stable(lane_a[g*DW +: DW]) && $stable(lane_b[g*DW +: DW]));
  end

  always_comb begin
    sel_a = '0;
    sel_b = '0;
    for (int i = 0; i < NLANE; i++)
      if (mask[i]) begin
        sel_a = sel_a | lane_a[i*DW +: DW];
        sel_b = sel_b | lane_b[i*DW +: DW];
      end
  end

  always_comb begin
    rdata = '0;
    rd_invalid = 1'b0;
    if (addr == ADDR_GLB) rdata = glb;
    else if (addr == ADDR_A || addr == ADDR_B) begin
      if (!onehot) rd_invalid = 1'b1;
      else rdata = (addr == ADDR_A) ? sel_a : sel_b;
    end
  end

  // R6
  invalid_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_invalid |-> rdata == '0);
  // R7
  pll_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pd_n || glob_pd) |-> !pll_en);
  // R9
  unmapped_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr != ADDR_GLB && addr != ADDR_A && addr != ADDR_B) |-> (rdata == '0 && !rd_invalid));
  // R2
  glb_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr == ADDR_GLB) |=> {loop_bw, mpy} == {$past(wdata[9:8]), $past(wdata[3:0])});
endmodule

// File: tb/sim_lane_cfg_bank.sv
module sim_lane_cfg_bank;
  logic clk = 0, rst_n = 0, we = 0, pd_n = 1, glob_pd = 0;
  logic [7:0] addr = 8'h00;
  logic [15:0] wdata = 0, rdata;
  logic rd_invalid, pll_en;
  logic [1:0] loop_bw;
  logic [3:0] mpy;
  logic [63:0] lane_a, lane_b;
  int n_chk = 0, n_fail = 0;
  logic [15:0] m_glb;
  logic [15:0] m_a [4];
  logic [15:0] m_b [4];

  always #2.5 clk = ~clk;

  lane_cfg_bank u0 (.clk(clk), .rst_n(rst_n), .we(we), .addr(addr), .wdata(wdata),
    .rdata(rdata), .rd_invalid(rd_invalid), .pd_n(pd_n), .glob_pd(glob_pd),
    .pll_en(pll_en), .loop_bw(loop_bw), .mpy(mpy), .lane_a(lane_a), .lane_b(lane_b));

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic is_onehot(logic [3:0] m);
    return (m == 4'b0001) || (m == 4'b0010) || (m == 4'b0100) || (m == 4'b1000);
  endfunction

  function automatic logic [16:0] exp_read(logic [7:0] a);
    logic [3:0] m = m_glb[15:12];
    logic [15:0] d = 0;
    if (a == 8'h06) return {1'b0, m_glb};
    if (a != 8'h07 && a != 8'h08) return 17'h0;
    if (!is_onehot(m)) return {1'b1, 16'h0};
    for (int i = 0; i < 4; i++) if (m[i]) d = (a == 8'h07) ? m_a[i] : m_b[i];
    return {1'b0, d};
  endfunction

  task automatic model_wr(logic [7:0] a, logic [15:0] d);
    if (a == 8'h06) m_glb = d;
    for (int i = 0; i < 4; i++)
      if (m_glb[12+i] && a != 8'h06) begin
        if (a == 8'h07) m_a[i] = d;
        if (a == 8'h08) m_b[i] = d;
      end
  endtask

  task automatic check_outs(string req);
    for (int i = 0; i < 4; i++) begin
      chk({req, " R3 lane_a"}, lane_a[i*16 +: 16], m_a[i]);
      chk({req, " R4 lane_b"}, lane_b[i*16 +: 16], m_b[i]);
    end
    chk({req, " R7 pll_en"}, pll_en, m_glb[4] & pd_n & ~glob_pd);
    chk({req, " R8 mpy/bw"}, {loop_bw, mpy}, {m_glb[9:8], m_glb[3:0]});
  endtask

  task automatic do_read(string req, logic [7:0] a);
    @(negedge clk);
    addr = a;
    #1;
    chk(req, {rd_invalid, rdata}, exp_read(a));
  endtask

  task automatic do_write(logic [7:0] a, logic [15:0] d, logic early_chk);
    @(negedge clk);
    we = 1; addr = a; wdata = d;
    #1;
    if (early_chk) check_outs("R10 before edge");
    @(negedge clk);
    we = 0;
    model_wr(a, d);
    #1;
    check_outs("after write");
  endtask

  initial begin
    #(5.0 * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED));
    m_glb = 16'hF115;
    for (int i = 0; i < 4; i++) begin m_a[i] = 0; m_b[i] = 0; end
    #12 rst_n = 1;
    // R1 reset state
    do_read("R1 global reset", 8'h06);
    check_outs("R1 reset");
    do_read("R6 all-lane mask read", 8'h07);
    // R3 broadcast to all lanes, then R10 timing
    do_write(8'h07, 16'hA5A5, 1);
    do_write(8'h08, 16'h3C3C, 1);
    // R2 spare bits, mask lane 2
    do_write(8'h06, 16'h4C65, 1);
    do_read("R2 spare readback", 8'h06);
    do_write(8'h07, 16'h1234, 1);
    do_read("R5 lane2 read", 8'h07);
    do_read("R5 lane2 read B", 8'h08);
    // R6 empty mask
    do_write(8'h06, 16'h0115, 0);
    do_read("R6 zero mask", 8'h08);
    do_write(8'h08, 16'hFFFF, 0);
    // R9 unmapped
    do_write(8'h09, 16'hDEAD, 0);
    do_write(8'h05, 16'hBEEF, 0);
    do_read("R9 unmapped read", 8'h09);
    do_read("R1 global after unmapped", 8'h06);
    // R7 power-down combos
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      {pd_n, glob_pd} = k[1:0];
      #1 chk("R7 pll gating", pll_en, m_glb[4] & pd_n & ~glob_pd);
    end
    pd_n = 1; glob_pd = 0;
    for (int it = 0; it < 400; it++) begin
      int op = $urandom % 6;
      logic [15:0] d = 16'($urandom);
      if (op == 0) begin
        if ($urandom % 3 != 0) d[15:12] = 4'b0001 << ($urandom % 4);
        do_write(8'h06, d, 0);
      end else if (op == 1) do_write(8'h07, d, 0);
      else if (op == 2) do_write(8'h08, d, 0);
      else if (op == 3) do_write(8'h10 | 8'($urandom % 16), d, 0);
      else begin
        logic [7:0] a;
        case ($urandom % 4)
          0: a = 8'h06;
          1: a = 8'h07;
          2: a = 8'h08;
          default: a = 8'h20 | 8'($urandom % 16);
        endcase
        do_read("R5/R6/R9 random read", a);
      end
      pd_n = 1'($urandom); glob_pd = 1'($urandom);
      #1 check_outs("random");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule